// File: doc/BRIEF.md
# Bit-Serial Reed-Solomon (204,188) Encoder

This block adds sixteen check bytes to every group of 188 message bytes, forming a 204-byte systematic Reed-Solomon codeword over GF(256). The field is built from x^8+x^4+x^3+x^2+1 (0x11D). The generator polynomial has the sixteen consecutive roots alpha^0 to alpha^15. The block sits between a serial bit source and a bit-serial convolutional coder, so both of its data edges are one bit wide.

Incoming bits are gathered into bytes, most significant bit first. Each completed byte is handed unchanged to the output serialiser and, in the same cycle, folded into a byte-wide division register that holds the running remainder. After the 188th byte the input is held off for sixteen byte slots. During that time the remainder bytes are shifted out, highest order first, with the division feedback forced to zero. The generator coefficients are computed by functions during elaboration, so the multipliers in the division register are constant-coefficient.

Top module: `rs_byte_encoder`

## Requirements
- R1: While reset is high and on the cycle after it, outValid and outSof are 0 and inReady is 1.
- R2: Bits are packed MSB first: the first accepted bit of each group of eight becomes bit 7 of the byte. Output bytes are sent MSB first.
- R3: Output bytes 0 to 187 of each codeword equal the accepted message bytes, in order.
- R4: Output bytes 188 to 203 are the remainder of m(x)*x^16 divided by g(x) = (x+alpha^0)(x+alpha^1)...(x+alpha^15) over GF(256) with polynomial 0x11D and alpha = 0x02. They are sent highest-order coefficient first, and the full codeword evaluates to zero at alpha^0 through alpha^15.
- R5: An all-zero message produces sixteen zero check bytes.
- R6: After the eighth bit of the 188th message byte is accepted, inReady is 0 for exactly 128 cycles and then returns to 1. It is 1 at all other times.
- R7: outSof is 1 only with the first output bit of each codeword, that is, once every 1632 output bits.
- R8: With input offered on every cycle, codewords follow one another with no bit lost or overwritten. Each codeword's check bytes depend only on its own message.
- R9: A cycle with inValid low accepts no bit. A message delivered with idle gaps produces the same codeword as the same message delivered without gaps.
- R10: The first bit of a byte appears on outBit, with outValid high, in the cycle after the byte's eighth input bit is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inBit | input | 1 | Serial message bit |
| inValid | input | 1 | inBit carries a bit this cycle |
| inReady | output | 1 | Block takes the bit this cycle when inValid is high |
| outBit | output | 1 | Serial codeword bit |
| outValid | output | 1 | outBit carries a codeword bit |
| outSof | output | 1 | Marks the first bit of a codeword |

## Verification
The hardest situation to reach is the handover at the end of a codeword. There, the last check byte is still being serialised while the next message is already being gathered, and the division register must start from zero for the new message. The stimulus reaches it by holding inValid high across two random messages sent back to back. The bench counts the cycles in which the second message's first bit waits for inReady and checks both codewords against a polynomial-division model and a root evaluation. A further run spreads idle gaps through a message so that byte completions land while the serialiser is already empty.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  // Largest parity count the coefficient function supports.
  localparam int MAX_PAR = 32;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic loadData;   // a message byte is complete: send it and fold it into the remainder
    logic loadPar;    // next remainder byte goes to the serialiser, remainder shifts
    logic clearPar;   // treat the remainder as zero (first byte of a codeword)
    logic markSof;    // the byte being loaded opens a codeword
  } enc_strobe_t;

  // Multiply two field elements, reducing by the given field polynomial.
  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b,
                                       input logic [8:0] poly);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ({sh[6:0], 1'b0} ^ poly[7:0]) : {sh[6:0], 1'b0};
    end
    return acc;
  endfunction

  // Coefficients g0..g(nPar-1) of prod (x + alpha^(firstRoot+i)); the leading 1 is implied.
  function automatic logic [MAX_PAR*8-1:0] genCoeffs(input int nPar, input logic [8:0] poly,
                                                     input int firstRoot);
    logic [7:0] g [0:MAX_PAR];
    logic [7:0] root;
    logic [MAX_PAR*8-1:0] res;
    for (int i = 0; i <= MAX_PAR; i++) g[i] = 8'h00;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < firstRoot; i++) root = gfMul(root, 8'h02, poly);
    for (int i = 0; i < MAX_PAR; i++) begin
      if (i < nPar) begin
        for (int j = MAX_PAR; j >= 1; j--) begin
          if (j <= i + 1) g[j] = g[j-1] ^ gfMul(g[j], root, poly);
        end
        g[0] = gfMul(g[0], root, poly);
        root = gfMul(root, 8'h02, poly);
      end
    end
    res = '0;
    for (int i = 0; i < MAX_PAR; i++) res[i*8 +: 8] = g[i];
    return res;
  endfunction

endpackage

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int N_DATA = 188,
  parameter int N_PAR  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byteDone,
  input  logic        serLast,
  output enc_strobe_t stb,
  output logic        inReady
);
  localparam int DW = (N_DATA > 1) ? $clog2(N_DATA) : 1;
  localparam int PW = (N_PAR > 1) ? $clog2(N_PAR) : 1;
  localparam logic [DW-1:0] DATA_LAST = DW'(N_DATA - 1);
  localparam logic [PW-1:0] PAR_LAST  = PW'(N_PAR - 1);

  logic          inParity;
  logic [DW-1:0] dataCnt;
  logic [PW-1:0] parCnt;

  assign inReady = !inParity;

  always_comb begin
    stb          = '0;
    stb.loadData = byteDone;
    stb.loadPar  = inParity && serLast;
    stb.clearPar = byteDone && (dataCnt == '0);
    stb.markSof  = byteDone && (dataCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inParity <= 1'b0;
      dataCnt  <= '0;
      parCnt   <= '0;
    end else begin
      if (stb.loadData) begin
        if (dataCnt == DATA_LAST) begin
          dataCnt  <= '0;
          inParity <= 1'b1;
        end else begin
          dataCnt <= dataCnt + 1'b1;
        end
      end
      if (stb.loadPar) begin
        if (parCnt == PAR_LAST) begin
          parCnt   <= '0;
          inParity <= 1'b0;
        end else begin
          parCnt <= parCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rs_enc_dp.sv
module rs_enc_dp
  import rs_enc_pkg::*;
#(
  parameter int         N_PAR      = 16,
  parameter logic [8:0] FIELD_POLY = 9'h11D,
  parameter int         FIRST_ROOT = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inBit,
  input  logic        inValid,
  input  logic        inReady,
  input  enc_strobe_t stb,
  output logic        byteDone,
  output logic        serLast,
  output logic        outBit,
  output logic        outValid,
  output logic        outSof
);
  localparam logic [MAX_PAR*8-1:0] GEN = genCoeffs(N_PAR, FIELD_POLY, FIRST_ROOT);

  // Serial-to-byte packing, MSB first.
  logic [2:0] bitCnt;
  logic [6:0] inShift;
  logic [7:0] newByte;
  logic       accept;

  assign accept   = inValid && inReady;
  assign byteDone = accept && (bitCnt == 3'd7);
  assign newByte  = {inShift, inBit};

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt  <= '0;
      inShift <= '0;
    end else if (accept) begin
      bitCnt  <= bitCnt + 3'd1;
      inShift <= {inShift[5:0], inBit};
    end
  end

  // Byte-wide division register for the remainder.
  logic [7:0] par     [N_PAR];
  logic [7:0] parBase [N_PAR];
  logic [7:0] parNext [N_PAR];
  logic [7:0] fb;

  always_comb begin
    for (int k = 0; k < N_PAR; k++) parBase[k] = stb.clearPar ? 8'h00 : par[k];
  end

  assign fb = stb.loadPar ? 8'h00 : (newByte ^ parBase[N_PAR-1]);

  for (genvar k = 0; k < N_PAR; k++) begin : g_tap
    if (k == 0) begin : g_low
      assign parNext[k] = gfMul(fb, GEN[7:0], FIELD_POLY);
    end else begin : g_up
      assign parNext[k] = parBase[k-1] ^ gfMul(fb, GEN[k*8 +: 8], FIELD_POLY);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_PAR; k++) par[k] <= 8'h00;
    end else if (stb.loadData || stb.loadPar) begin
      for (int k = 0; k < N_PAR; k++) par[k] <= parNext[k];
    end
  end

  // Byte-to-serial output, MSB first.
  logic [7:0] serReg;
  logic [3:0] serCnt;
  logic       sofPend;

  assign serLast  = (serCnt <= 4'd1);
  assign outBit   = serReg[7];
  assign outValid = (serCnt != 4'd0);
  assign outSof   = sofPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      serReg  <= '0;
      serCnt  <= '0;
      sofPend <= 1'b0;
    end else if (stb.loadData) begin
      serReg  <= newByte;
      serCnt  <= 4'd8;
      sofPend <= stb.markSof;
    end else if (stb.loadPar) begin
      serReg  <= par[N_PAR-1];
      serCnt  <= 4'd8;
      sofPend <= 1'b0;
    end else if (serCnt != 4'd0) begin
      serReg  <= {serReg[6:0], 1'b0};
      serCnt  <= serCnt - 4'd1;
      sofPend <= 1'b0;
    end
  end
endmodule

// File: rtl/rs_byte_encoder.sv
module rs_byte_encoder
  import rs_enc_pkg::*;
#(
  parameter int         N_TOTAL    = 204,
  parameter int         N_PAR      = 16,
  parameter logic [8:0] FIELD_POLY = 9'h11D,
  parameter int         FIRST_ROOT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic inBit,
  input  logic inValid,
  output logic inReady,
  output logic outBit,
  output logic outValid,
  output logic outSof
);
  localparam int N_DATA = N_TOTAL - N_PAR;

  enc_strobe_t stb;
  logic        byteDone;
  logic        serLast;

  rs_enc_ctrl #(.N_DATA(N_DATA), .N_PAR(N_PAR)) u_ctrl (
    .clk(clk), .rst(rst), .byteDone(byteDone), .serLast(serLast),
    .stb(stb), .inReady(inReady)
  );

  rs_enc_dp #(.N_PAR(N_PAR), .FIELD_POLY(FIELD_POLY), .FIRST_ROOT(FIRST_ROOT)) u_dp (
    .clk(clk), .rst(rst), .inBit(inBit), .inValid(inValid), .inReady(inReady),
    .stb(stb), .byteDone(byteDone), .serLast(serLast),
    .outBit(outBit), .outValid(outValid), .outSof(outSof)
  );
endmodule

// File: rtl/rs_enc_checker.sv
module rs_enc_checker (
  input logic clk,
  input logic rst,
  input logic inReady,
  input logic outValid,
  input logic outSof,
  input logic loadData,
  input logic loadPar,
  input logic serLast
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> (!outValid && !outSof && inReady));

  // R8: a byte is only loaded once the serialiser is on its last bit or empty
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst) loadData |-> serLast);

  assert_par_gated_R6: assert property (@(posedge clk) disable iff (rst) loadPar |-> !inReady);

  assert_ready_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(inReady) |-> $past(loadData));

  assert_sof_valid_R7: assert property (@(posedge clk) disable iff (rst) outSof |-> outValid);

  assert_sof_single_R7: assert property (@(posedge clk) disable iff (rst) outSof |=> !outSof);

  assert_load_shows_R10: assert property (@(posedge clk) disable iff (rst)
    (loadData || loadPar) |=> outValid);
endmodule

bind rs_byte_encoder rs_enc_checker u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .outValid(outValid), .outSof(outSof),
  .loadData(stb.loadData), .loadPar(stb.loadPar), .serLast(serLast)
);

// File: tb/rs_byte_encoder_tb.sv
module rs_byte_encoder_tb;
  localparam int NT = 204;
  localparam int NP = 16;
  localparam int ND = NT - NP;
  localparam int CWBITS = NT * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inBit = 1'b0;
  logic inValid = 1'b0;
  logic inReady, outBit, outValid, outSof;

  always #4 clk = ~clk;

  rs_byte_encoder u_dut (
    .clk(clk), .rst(rst), .inBit(inBit), .inValid(inValid), .inReady(inReady),
    .outBit(outBit), .outValid(outValid), .outSof(outSof)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] gen   [0:NP];
  logic [7:0] msg   [0:1][0:ND-1];
  logic [7:0] rxBytes [0:2*NT-1];
  logic [7:0] acc = 8'h00;
  int rxBits = 0;
  int sofCnt = 0;
  int sofBad = 0;
  int rdyLow = 0;

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = 0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1D) : {x[6:0], 1'b0};
    end
    return p;
  endfunction

  initial begin
    logic [7:0] r;
    for (int i = 0; i <= NP; i++) gen[i] = 0;
    gen[0] = 1;
    r = 1;
    for (int i = 0; i < NP; i++) begin
      for (int j = i + 1; j >= 1; j--) gen[j] = gen[j-1] ^ fmul(gen[j], r);
      gen[0] = fmul(gen[0], r);
      r = fmul(r, 8'h02);
    end
  end

  // Output collector
  always @(negedge clk) begin
    if (!rst && outValid) begin
      acc = {acc[6:0], outBit};
      if (outSof) begin
        sofCnt++;
        if (rxBits % CWBITS != 0) sofBad++;
      end
      rxBits++;
      if (rxBits % 8 == 0 && rxBits / 8 <= 2 * NT) rxBytes[rxBits/8-1] = acc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rxBits = 0;
    sofCnt = 0;
    sofBad = 0;
    rdyLow = 0;
  endtask

  task automatic sendBit(input logic b, input int gap);
    repeat (gap) begin
      @(negedge clk);
      inValid = 1'b0;
    end
    @(negedge clk);
    inValid = 1'b1;
    inBit = b;
    while (!inReady) begin
      rdyLow++;
      @(negedge clk);
    end
  endtask

  task automatic sendCw(input int cw, input int gap);
    for (int i = 0; i < ND; i++)
      for (int b = 7; b >= 0; b--)
        sendBit(msg[cw][i][b], (gap > 0 && (b % 3 == 0)) ? gap : 0);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitBits(input int n);
    int t = 0;
    while (rxBits < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic checkCw(input int cw, input int base, input string tag);
    logic [7:0] rem [0:NP-1];
    logic [7:0] fb, s, r;
    int bad, fa, fe;
    for (int k = 0; k < NP; k++) rem[k] = 0;
    for (int i = 0; i < ND; i++) begin
      fb = msg[cw][i] ^ rem[NP-1];
      for (int k = NP - 1; k >= 1; k--) rem[k] = rem[k-1] ^ fmul(fb, gen[k]);
      rem[0] = fmul(fb, gen[0]);
    end
    // R3: systematic part
    bad = 0; fa = 0; fe = 0;
    for (int i = 0; i < ND; i++)
      if (rxBytes[base+i] !== msg[cw][i]) begin
        if (bad == 0) begin fa = rxBytes[base+i]; fe = msg[cw][i]; end
        bad++;
      end
    check(bad == 0, "R3", {tag, " message byte"}, fa, fe);
    // R4: remainder, highest order first
    bad = 0; fa = 0; fe = 0;
    for (int p = 0; p < NP; p++)
      if (rxBytes[base+ND+p] !== rem[NP-1-p]) begin
        if (bad == 0) begin fa = rxBytes[base+ND+p]; fe = rem[NP-1-p]; end
        bad++;
      end
    check(bad == 0, "R4", {tag, " check byte"}, fa, fe);
    // R4: codeword vanishes at alpha^0..alpha^15
    bad = 0;
    r = 1;
    for (int j = 0; j < NP; j++) begin
      s = 0;
      for (int i = 0; i < NT; i++) s = fmul(s, r) ^ rxBytes[base+i];
      if (s != 0) bad++;
      r = fmul(r, 8'h02);
    end
    check(bad == 0, "R4", {tag, " nonzero syndromes"}, bad, 0);
  endtask

  task automatic tReset();
    doReset();
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    check(outSof == 1'b0, "R1", "outSof after reset", int'(outSof), 0);
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
  endtask

  task automatic tLatency();
    logic [7:0] v = 8'hA5;
    doReset();
    for (int b = 7; b >= 1; b--) sendBit(v[b], 0);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b0, "R10", "outValid before 8th bit", int'(outValid), 0);
    sendBit(v[0], 0);
    idle();
    check(outValid == 1'b1, "R10", "outValid after 8th bit", int'(outValid), 1);
    check(outSof == 1'b1, "R7", "outSof on first bit", int'(outSof), 1);
    check(outBit == 1'b1, "R2", "first output bit is MSB", int'(outBit), 1);
    waitBits(8);
    check(rxBytes[0] == v, "R2", "packed byte", rxBytes[0], v);
  endtask

  task automatic tZero();
    int nz = 0;
    for (int i = 0; i < ND; i++) msg[0][i] = 8'h00;
    doReset();
    sendCw(0, 0);
    idle();
    waitBits(CWBITS);
    for (int p = 0; p < NP; p++) if (rxBytes[ND+p] != 0) nz++;
    check(nz == 0, "R5", "nonzero check bytes for zero message", nz, 0);
    checkCw(0, 0, "zero");
  endtask

  task automatic tRamp();
    for (int i = 0; i < ND; i++) msg[0][i] = 8'(i * 7 + 3);
    doReset();
    sendCw(0, 0);
    check(rdyLow == 0, "R6", "ready-low cycles during message", rdyLow, 0);
    idle();
    waitBits(CWBITS);
    checkCw(0, 0, "ramp");
    check(sofCnt == 1, "R7", "codeword starts", sofCnt, 1);
    check(sofBad == 0, "R7", "misplaced codeword starts", sofBad, 0);
  endtask

  task automatic tBackToBack();
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < ND; i++) msg[c][i] = 8'($urandom);
    doReset();
    sendCw(0, 0);
    rdyLow = 0;
    sendCw(1, 0);
    check(rdyLow == 128, "R6", "ready-low cycles between codewords", rdyLow, 128);
    idle();
    waitBits(2 * CWBITS);
    check(rxBits == 2 * CWBITS, "R8", "output bits for two codewords", rxBits, 2 * CWBITS);
    checkCw(0, 0, "first");
    checkCw(1, NT, "second");
    check(sofCnt == 2 && sofBad == 0, "R7", "starts over two codewords", sofCnt, 2);
  endtask

  task automatic tGapped();
    for (int i = 0; i < ND; i++) msg[0][i] = 8'($urandom);
    doReset();
    sendCw(0, 2);
    idle();
    waitBits(CWBITS);
    check(rxBits == CWBITS, "R9", "output bits with idle gaps", rxBits, CWBITS);
    checkCw(0, 0, "gapped R9");
  endtask

  initial begin
    tReset();
    tLatency();
    tZero();
    tRamp();
    tBackToBack();
    tGapped();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule